// File: doc/BRIEF.md
# USB Transfer Descriptor Token Engine

This block keeps the 32-bit token word of one USB host transfer descriptor and updates it while the descriptor's transactions run. A descriptor fetcher hands it a token and a starting byte offset inside the first buffer page. The engine then asks the packet engine for one transaction at a time and states how many bytes that transaction should move. After each transaction, the packet engine reports success or failure and the number of bytes it actually moved.

On every successful report the engine lowers the remaining byte count, moves the in-page offset forward, advances the page index when a 4 KB page boundary is crossed, and flips the data toggle when the toggle is owned by the descriptor. A descriptor ends when its count reaches zero or when an IN transaction comes back short. At that point the updated token is presented together with a one-cycle retire strobe. If interrupt-on-complete is set, an interrupt request is raised at the following interrupt-threshold tick and held until it is acknowledged.

Token layout, which a neighbour decodes: bit 31 holds the data toggle, bits 30:16 hold the remaining byte count, bit 15 holds interrupt-on-complete, bits 14:12 hold the page index, and bits 11:0 pass through unchanged.

Top module: `qtd_token_engine`

## Requirements
- R1: A load whose count field (bits 30:16) exceeds 0x5000, or whose page field (bits 14:12) exceeds 4, starts no transaction. It gives a one-cycle `descError` in the cycle after the load, and `busy` stays low. A count of exactly 0x5000 on page 0 is accepted.
- R2: While busy, `xferLen` equals the smallest of three values: the remaining count, `maxPacket`, and 4096 minus the in-page offset.
- R3: A successful report lowers the count field by the bytes moved. A failed report (`doneOk`=0) leaves the token unchanged and repeats the same request.
- R4: A load with count 0 issues exactly one transaction of length 0. Its successful report retires the descriptor.
- R5: When a transaction carries the offset to 4096, the offset wraps to 0 and the page field increments.
- R6: A page crossing out of page 4 while bytes remain gives a `descError` pulse and returns to idle without a retire strobe. Ending exactly at the end of page 4 retires normally with the page field left at 4.
- R7: With `toggleCtl`=1, bit 31 flips on every successful report. With `toggleCtl`=0, bit 31 keeps its loaded value.
- R8: The descriptor retires when the count reaches zero, or when an IN transaction (`isIn`=1) moves fewer bytes than requested. `retireStrobe` is high for exactly the one cycle after the final report, `busy` is low from then on, and `tokenOut` shows the updated token.
- R9: With bit 15 set, `irq` rises only at the clock edge of the first `thresholdTick` after retirement, and stays high until `irqAck`. With bit 15 clear, no `irq` is raised.
- R10: For OUT transfers whose count is not a multiple of `maxPacket`, the last request carries the shorter remainder.
- R11: A synchronous `rst` returns the block to idle, with `busy`, `xferReq`, `irq`, `retireStrobe`, `descError` and `tokenOut` all at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| loadValid | input | 1 | Token and offset present, accepted when idle |
| loadToken | input | 32 | Token word from descriptor fetch |
| loadOffset | input | 12 | Starting byte offset in the current page |
| maxPacket | input | 11 | Maximum packet length of the endpoint |
| isIn | input | 1 | Transfer direction is IN |
| toggleCtl | input | 1 | 1: toggle is held in the token |
| xferReq | output | 1 | A transaction is requested |
| xferLen | output | 15 | Bytes requested for this transaction |
| doneValid | input | 1 | Completion report strobe |
| doneOk | input | 1 | Transaction succeeded |
| doneBytes | input | 15 | Bytes actually moved |
| thresholdTick | input | 1 | Interrupt-threshold tick |
| irqAck | input | 1 | Clears the interrupt request |
| busy | output | 1 | Descriptor active |
| tokenOut | output | 32 | Current and written-back token |
| retireStrobe | output | 1 | One-cycle retirement pulse |
| descError | output | 1 | One-cycle descriptor error pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the edges of the size calculation. An offset near the page end must cut the request to the room left in the page. A design that ignores the page room would request 512 bytes where 96 remain, and would never move the page index. A zero-length descriptor must still issue one request; a design that retires it at load time would never raise `xferReq`. A failed report must leave the count and toggle as they were, so a design that commits on any report shows a count that is too small. Crossing out of page 4 with bytes left must give an error, and ending exactly at that boundary must not. The interrupt must wait for a threshold tick and then stay up until acknowledged; a design that signals at retirement fires a cycle early.

// File: rtl/qtd_pkg.sv
package qtd_pkg;
  typedef struct packed {
    logic load;
    logic commit;
  } dpCtl_t;
endpackage

// File: rtl/qtd_datapath.sv
module qtd_datapath
  import qtd_pkg::*;
#(
  parameter int CountW   = 15,
  parameter int OffW     = 12,
  parameter int PageW    = 3,
  parameter int NumPages = 5,
  parameter int MaxPktW  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            ctl,
  input  logic [31:0]       loadToken,
  input  logic [OffW-1:0]   loadOffset,
  input  logic [MaxPktW-1:0] maxPacket,
  input  logic [CountW-1:0] doneBytes,
  input  logic              isIn,
  input  logic              toggleCtl,
  output logic [CountW-1:0] reqLen,
  output logic              loadBad,
  output logic              finishOk,
  output logic              pageOver,
  output logic              iocBit,
  output logic [31:0]       tokenWord
);
  localparam int PageBytes = 1 << OffW;
  localparam int MaxCount  = NumPages * PageBytes;
  localparam logic [CountW-1:0] PageBytesV = CountW'(PageBytes);
  localparam logic [CountW-1:0] MaxCountV  = CountW'(MaxCount);
  localparam logic [PageW-1:0]  LastPageV  = PageW'(NumPages - 1);
  localparam int LowW = 32 - 2 - CountW - PageW;

  logic [CountW-1:0] remaining;
  logic [OffW-1:0]   offset;
  logic [PageW-1:0]  page;
  logic              toggle;
  logic              ioc;
  logic [LowW-1:0]   lowBits;

  logic [CountW-1:0] room, moved, remAfter;
  logic [CountW:0]   sumOff;
  logic              carry;

  always_comb begin
    room   = PageBytesV - CountW'(offset);
    reqLen = remaining;
    if (CountW'(maxPacket) < reqLen) reqLen = CountW'(maxPacket);
    if (room < reqLen) reqLen = room;
    moved    = (doneBytes < reqLen) ? doneBytes : reqLen;
    sumOff   = (CountW+1)'(offset) + (CountW+1)'(moved);
    carry    = sumOff >= (CountW+1)'(PageBytes);
    remAfter = remaining - moved;
    finishOk = (remAfter == '0) || (isIn && (moved < reqLen));
    pageOver = carry && (page == LastPageV) && !finishOk;
    loadBad  = (loadToken[30:16] > MaxCountV) || (loadToken[14:12] > LastPageV);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
      offset    <= '0;
      page      <= '0;
      toggle    <= 1'b0;
      ioc       <= 1'b0;
      lowBits   <= '0;
    end else if (ctl.load) begin
      toggle    <= loadToken[31];
      remaining <= loadToken[30:16];
      ioc       <= loadToken[15];
      page      <= loadToken[14:12];
      lowBits   <= loadToken[LowW-1:0];
      offset    <= loadOffset;
    end else if (ctl.commit) begin
      remaining <= remAfter;
      offset    <= sumOff[OffW-1:0];
      toggle    <= toggle ^ toggleCtl;
      if (carry && page != LastPageV) page <= page + 1'b1;
    end
  end

  assign iocBit    = ioc;
  assign tokenWord = {toggle, remaining, ioc, page, lowBits};
endmodule

// File: rtl/qtd_control.sv
module qtd_control
  import qtd_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   loadValid,
  input  logic   doneValid,
  input  logic   doneOk,
  input  logic   thresholdTick,
  input  logic   irqAck,
  input  logic   loadBad,
  input  logic   finishOk,
  input  logic   pageOver,
  input  logic   iocBit,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   retireStrobe,
  output logic   descError,
  output logic   irq
);
  typedef enum logic {S_IDLE, S_ACTIVE} state_t;
  state_t state;
  logic   irqPending;
  logic   goodReport;

  assign goodReport = (state == S_ACTIVE) && doneValid && doneOk;
  assign busy       = (state == S_ACTIVE);

  always_comb begin
    ctl.load   = (state == S_IDLE) && loadValid && !loadBad;
    ctl.commit = goodReport && !pageOver;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      retireStrobe <= 1'b0;
      descError    <= 1'b0;
      irqPending   <= 1'b0;
      irq          <= 1'b0;
    end else begin
      retireStrobe <= 1'b0;
      descError    <= 1'b0;
      if (irqAck) irq <= 1'b0;
      if (thresholdTick && irqPending) begin
        irq        <= 1'b1;
        irqPending <= 1'b0;
      end
      case (state)
        S_IDLE: if (loadValid) begin
          if (loadBad) descError <= 1'b1;
          else         state     <= S_ACTIVE;
        end
        S_ACTIVE: if (goodReport) begin
          if (pageOver) begin
            descError <= 1'b1;
            state     <= S_IDLE;
          end else if (finishOk) begin
            retireStrobe <= 1'b1;
            state        <= S_IDLE;
            if (iocBit) irqPending <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qtd_token_engine.sv
module qtd_token_engine
  import qtd_pkg::*;
#(
  parameter int CountW   = 15,
  parameter int OffW     = 12,
  parameter int PageW    = 3,
  parameter int NumPages = 5,
  parameter int MaxPktW  = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               loadValid,
  input  logic [31:0]        loadToken,
  input  logic [OffW-1:0]    loadOffset,
  input  logic [MaxPktW-1:0] maxPacket,
  input  logic               isIn,
  input  logic               toggleCtl,
  output logic               xferReq,
  output logic [CountW-1:0]  xferLen,
  input  logic               doneValid,
  input  logic               doneOk,
  input  logic [CountW-1:0]  doneBytes,
  input  logic               thresholdTick,
  input  logic               irqAck,
  output logic               busy,
  output logic [31:0]        tokenOut,
  output logic               retireStrobe,
  output logic               descError,
  output logic               irq
);
  dpCtl_t ctl;
  logic   loadBad, finishOk, pageOver, iocBit;

  qtd_datapath #(
    .CountW(CountW), .OffW(OffW), .PageW(PageW),
    .NumPages(NumPages), .MaxPktW(MaxPktW)
  ) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .loadToken(loadToken), .loadOffset(loadOffset), .maxPacket(maxPacket),
    .doneBytes(doneBytes), .isIn(isIn), .toggleCtl(toggleCtl),
    .reqLen(xferLen), .loadBad(loadBad), .finishOk(finishOk),
    .pageOver(pageOver), .iocBit(iocBit), .tokenWord(tokenOut)
  );

  qtd_control u_ctl (
    .clk(clk), .rst(rst), .loadValid(loadValid), .doneValid(doneValid),
    .doneOk(doneOk), .thresholdTick(thresholdTick), .irqAck(irqAck),
    .loadBad(loadBad), .finishOk(finishOk), .pageOver(pageOver),
    .iocBit(iocBit), .ctl(ctl), .busy(busy), .retireStrobe(retireStrobe),
    .descError(descError), .irq(irq)
  );

  assign xferReq = busy;
endmodule

// File: rtl/qtd_token_engine_checker.sv
module qtd_token_engine_checker (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic [14:0] xferLen,
  input logic [10:0] maxPacket,
  input logic        retireStrobe,
  input logic        descError,
  input logic        doneValid,
  input logic        doneOk,
  input logic [31:0] tokenOut,
  input logic        irq,
  input logic        irqAck,
  input logic        thresholdTick
);
  AST_LEN_WITHIN_PACKET: assert property (@(posedge clk) disable iff (rst)
    busy |-> (xferLen <= 15'(maxPacket))); // R2
  AST_LEN_WITHIN_PAGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (xferLen <= 15'd4096)); // R2
  AST_FAIL_KEEPS_TOKEN: assert property (@(posedge clk) disable iff (rst)
    (busy && doneValid && !doneOk) |=> $stable(tokenOut)); // R3
  AST_PAGE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (tokenOut[14:12] <= 3'd4)); // R5
  AST_RETIRE_IDLE: assert property (@(posedge clk) disable iff (rst)
    retireStrobe |-> !busy); // R8
  AST_RETIRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    retireStrobe |=> !retireStrobe); // R8
  AST_NO_RETIRE_WITH_ERROR: assert property (@(posedge clk) disable iff (rst)
    !(retireStrobe && descError)); // R6
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (irq && !irqAck) |=> irq); // R9
  AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    (!irq ##1 irq) |-> $past(thresholdTick)); // R9
endmodule

bind qtd_token_engine qtd_token_engine_checker u_chk (
  .clk(clk), .rst(rst), .busy(busy), .xferLen(xferLen), .maxPacket(maxPacket),
  .retireStrobe(retireStrobe), .descError(descError), .doneValid(doneValid),
  .doneOk(doneOk), .tokenOut(tokenOut), .irq(irq), .irqAck(irqAck),
  .thresholdTick(thresholdTick)
);

// File: tb/qtd_token_engine_bench.sv
module qtd_token_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadValid = 1'b0;
  logic [31:0] loadToken = '0;
  logic [11:0] loadOffset = '0;
  logic [10:0] maxPacket = 11'd512;
  logic        isIn = 1'b0;
  logic        toggleCtl = 1'b0;
  logic        xferReq;
  logic [14:0] xferLen;
  logic        doneValid = 1'b0;
  logic        doneOk = 1'b0;
  logic [14:0] doneBytes = '0;
  logic        thresholdTick = 1'b0;
  logic        irqAck = 1'b0;
  logic        busy;
  logic [31:0] tokenOut;
  logic        retireStrobe;
  logic        descError;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  qtd_token_engine u_qtd_token_engine (
    .clk(clk), .rst(rst), .loadValid(loadValid), .loadToken(loadToken),
    .loadOffset(loadOffset), .maxPacket(maxPacket), .isIn(isIn),
    .toggleCtl(toggleCtl), .xferReq(xferReq), .xferLen(xferLen),
    .doneValid(doneValid), .doneOk(doneOk), .doneBytes(doneBytes),
    .thresholdTick(thresholdTick), .irqAck(irqAck), .busy(busy),
    .tokenOut(tokenOut), .retireStrobe(retireStrobe), .descError(descError),
    .irq(irq)
  );

  function automatic logic [31:0] mkTok(bit tg, int cnt, bit io, int pg);
    return {tg, 15'(cnt), io, 3'(pg), 12'h000};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic loadDesc(logic [31:0] tok, logic [11:0] off);
    loadToken = tok; loadOffset = off; loadValid = 1'b1;
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  task automatic report(bit ok, int bytes);
    doneOk = ok; doneBytes = 15'(bytes); doneValid = 1'b1;
    @(negedge clk);
    doneValid = 1'b0;
  endtask

  task automatic tick();
    thresholdTick = 1'b1;
    @(negedge clk);
    thresholdTick = 1'b0;
  endtask

  task automatic testReset();
    check("R11 busy", 32'(busy), 0);
    check("R11 xferReq", 32'(xferReq), 0);
    check("R11 irq", 32'(irq), 0);
    check("R11 token", tokenOut, 0);
    check("R11 descError", 32'(descError), 0);
  endtask

  task automatic testOutMulti();
    maxPacket = 11'd512; isIn = 1'b0; toggleCtl = 1'b1;
    loadDesc(mkTok(0, 1300, 1, 0), 12'd0);
    check("R2 first len", 32'(xferLen), 512);
    check("R8 busy", 32'(busy), 1);
    report(1, 512);
    check("R3 count after 512", 32'(tokenOut[30:16]), 788);
    check("R7 toggle flipped", 32'(tokenOut[31]), 1);
    report(0, 512);
    check("R3 failed keeps token", tokenOut, mkTok(1, 788, 1, 0));
    check("R3 failed repeats len", 32'(xferLen), 512);
    report(1, 512);
    check("R10 remainder len", 32'(xferLen), 276);
    check("R7 toggle back", 32'(tokenOut[31]), 0);
    report(1, 276);
    check("R8 retire strobe", 32'(retireStrobe), 1);
    check("R8 idle", 32'(busy), 0);
    check("R8 token", tokenOut, mkTok(1, 0, 1, 0));
    check("R9 no irq before tick", 32'(irq), 0);
    @(negedge clk);
    check("R8 strobe single", 32'(retireStrobe), 0);
    check("R9 still no irq", 32'(irq), 0);
    tick();
    check("R9 irq at tick", 32'(irq), 1);
    repeat (3) @(negedge clk);
    check("R9 irq held", 32'(irq), 1);
    irqAck = 1'b1; @(negedge clk); irqAck = 1'b0;
    check("R9 irq cleared", 32'(irq), 0);
  endtask

  task automatic testPageCross();
    maxPacket = 11'd512; isIn = 1'b0; toggleCtl = 1'b0;
    loadDesc(mkTok(1, 600, 0, 1), 12'd4000);
    check("R2 page room len", 32'(xferLen), 96);
    report(1, 96);
    check("R5 page incremented", 32'(tokenOut[14:12]), 2);
    check("R3 count 504", 32'(tokenOut[30:16]), 504);
    check("R2 fresh page len", 32'(xferLen), 504);
    check("R7 toggle kept", 32'(tokenOut[31]), 1);
    report(1, 504);
    check("R8 retire", 32'(retireStrobe), 1);
    tick();
    check("R9 no irq without ioc", 32'(irq), 0);
  endtask

  task automatic testZeroLen();
    loadDesc(mkTok(0, 0, 0, 0), 12'd10);
    check("R4 request issued", 32'(xferReq), 1);
    check("R4 zero len", 32'(xferLen), 0);
    report(1, 0);
    check("R4 retired", 32'(retireStrobe), 1);
    check("R4 idle", 32'(busy), 0);
  endtask

  task automatic testInShort();
    maxPacket = 11'd64; isIn = 1'b1; toggleCtl = 1'b0;
    loadDesc(mkTok(0, 1000, 0, 0), 12'd0);
    check("R2 mps len", 32'(xferLen), 64);
    report(1, 30);
    check("R8 short IN retire", 32'(retireStrobe), 1);
    check("R8 short IN count", 32'(tokenOut[30:16]), 970);
    isIn = 1'b0;
  endtask

  task automatic testBadLoad();
    loadDesc(mkTok(0, 'h5001, 0, 0), 12'd0);
    check("R1 count error", 32'(descError), 1);
    check("R1 not busy", 32'(busy), 0);
    loadDesc(mkTok(0, 100, 0, 5), 12'd0);
    check("R1 page error", 32'(descError), 1);
    check("R1 page not busy", 32'(xferReq), 0);
    maxPacket = 11'd512;
    loadDesc(mkTok(0, 'h5000, 0, 0), 12'd0);
    check("R1 max accepted", 32'(busy), 1);
    check("R1 no error", 32'(descError), 0);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R11 reset idles", 32'(busy), 0);
    check("R11 reset token", tokenOut, 0);
  endtask

  task automatic testLastPage();
    maxPacket = 11'd512; isIn = 1'b0;
    loadDesc(mkTok(0, 200, 0, 4), 12'd4000);
    report(1, 96);
    check("R6 overflow error", 32'(descError), 1);
    check("R6 no retire", 32'(retireStrobe), 0);
    check("R6 idle", 32'(busy), 0);
    @(negedge clk);
    loadDesc(mkTok(0, 96, 0, 4), 12'd4000);
    report(1, 96);
    check("R6 exact end retires", 32'(retireStrobe), 1);
    check("R6 exact end no error", 32'(descError), 0);
    check("R6 page stays 4", 32'(tokenOut[14:12]), 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testOutMulti();
    testPageCross();
    testZeroLen();
    testInShort();
    testBadLoad();
    testLastPage();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #40000;
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule